// File: doc/BRIEF.md
# Bit-Manipulation ALU for an 8-bit Processor Core

This block is the data and flag engine behind the prefixed bit-manipulation instructions of a classic 8-bit processor. It is purely combinational. It takes one operand byte, the current flag byte, a two-bit instruction group and a three-bit selector. It returns the processed byte and the flag byte that the instruction leaves behind. The surrounding core fetches the opcode, reads the register or memory operand, and writes back both outputs. This block does none of that, and it keeps no cycle counts.

The group code picks one of four families. The first is a family of eight rotates and shifts. The second is a single-bit test. The other two clear or set one bit. For the rotate/shift family the selector names the kind of operation; for the other three it is the bit index. The flag byte matches the processor exactly, down to the two undocumented copy bits (5 and 3). It also follows the fixed pattern that the bit test leaves.

Top module: `bitops_alu`

## Requirements
- R1: The group input selects the family: 0 is rotate/shift, 1 is bit test, 2 is bit clear, 3 is bit set.
- R2: In the rotate/shift group, selector 0 rotates the byte left and selector 1 rotates it right. The bit that wraps round goes into both the vacated position and the carry (flag bit 0).
- R3: Selector 2 rotates left through the carry and selector 3 rotates right through the carry. The old carry (incoming flag bit 0) fills the vacated position, and the new carry takes the bit pushed out.
- R4: Selector 4 shifts left and fills with 0. Selector 6 shifts left and fills with 1. Selector 5 shifts right and keeps bit 7. Selector 7 shifts right and fills bit 7 with 0. In each case carry takes the bit pushed out.
- R5: After any rotate/shift, the flags are set as follows. Result bits 7, 5 and 3 land in flag bits 7, 5 and 3. Flag bit 6 is 1 only when the result is zero. Flag bit 2 is 1 when the result holds an even number of ones. Flag bits 4 and 1 are 0.
- R6: In the bit test, flag bit 0 keeps its incoming value and flag bit 4 is 1. Flag bits 6 and 2 are both 1 when the operand bit chosen by the selector is 0, and both 0 otherwise. Flag bits 7 and 1 are 0. Flag bits 5 and 3 copy operand bits 5 and 3.
- R7: The bit test passes the operand through unchanged as its result.
- R8: Bit clear returns the operand with the bit chosen by the selector forced to 0. The outgoing flag byte equals the incoming one.
- R9: Bit set returns the operand with the bit chosen by the selector forced to 1. The outgoing flag byte equals the incoming one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Flag byte before the instruction |
| group_i | input | 2 | Instruction family (R1 encoding) |
| sel_i | input | 3 | Rotate/shift kind, or bit index |
| result_o | output | 8 | Processed byte |
| flags_o | output | 8 | Flag byte after the instruction |

## Verification
Two corners are the hardest to reach. One is a carry-through rotate whose old carry is the only 1 in the result. The other is a rotate whose pushed-out bit leaves a zero result with the carry set. In both, the zero, parity and carry flags depend on a single bit arriving from the flag input rather than the operand. Directed vectors place exactly these operand/carry pairs. The bench then sweeps every group, every selector and every operand value under incoming flag bytes with the carry both clear and set, and the undocumented bits both clear and set.

// File: rtl/bitops_pkg.sv
package bitops_pkg;
    localparam int DW    = 8;
    localparam int IDX_W = $clog2(DW);

    localparam int FB_CARRY = 0;
    localparam int FB_SUB   = 1;
    localparam int FB_PAR   = 2;
    localparam int FB_X3    = 3;
    localparam int FB_HALF  = 4;
    localparam int FB_X5    = 5;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLEAR = 2'd2,
        GRP_FORCE = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        K_ROL   = 3'd0,
        K_ROR   = 3'd1,
        K_ROLC  = 3'd2,
        K_RORC  = 3'd3,
        K_SHL0  = 3'd4,
        K_SHRA  = 3'd5,
        K_SHL1  = 3'd6,
        K_SHR0  = 3'd7
    } kind_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] flg;
    } alu_out_t;
endpackage

// File: rtl/rotshift_unit.sv
module rotshift_unit
    import bitops_pkg::*;
(
    input  logic [DW-1:0]    val_i,
    input  logic             cin_i,
    input  logic [2:0]       kind_i,
    output logic [DW-1:0]    res_o,
    output logic             cout_o
);
    logic go_right;
    logic fill;

    assign go_right = kind_i[0];

    always_comb begin
        fill = 1'b0;
        unique case (kind_i[2:1])
            2'd0: fill = go_right ? val_i[0] : val_i[DW-1];
            2'd1: fill = cin_i;
            2'd2: fill = go_right ? val_i[DW-1] : 1'b0;
            2'd3: fill = go_right ? 1'b0 : 1'b1;
            default: fill = 1'b0;
        endcase
    end

    always_comb begin
        if (go_right) begin
            res_o  = {fill, val_i[DW-1:1]};
            cout_o = val_i[0];
        end else begin
            res_o  = {val_i[DW-2:0], fill};
            cout_o = val_i[DW-1];
        end
    end
endmodule

// File: rtl/bitsel_unit.sv
module bitsel_unit
    import bitops_pkg::*;
(
    input  logic [DW-1:0]    val_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             picked_o,
    output logic [DW-1:0]    cleared_o,
    output logic [DW-1:0]    forced_o
);
    logic [DW-1:0] mask;

    for (genvar gi = 0; gi < DW; gi++) begin : g_mask
        assign mask[gi] = (idx_i == IDX_W'(gi));
    end

    assign picked_o  = |(val_i & mask);
    assign cleared_o = val_i & ~mask;
    assign forced_o  = val_i | mask;
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
    import bitops_pkg::*;
(
    input  logic [DW-1:0] res_i,
    input  logic          carry_i,
    output logic [DW-1:0] flg_o
);
    always_comb begin
        flg_o           = '0;
        flg_o[FB_CARRY] = carry_i;
        flg_o[FB_PAR]   = ~^res_i;
        flg_o[FB_X3]    = res_i[3];
        flg_o[FB_X5]    = res_i[5];
        flg_o[FB_ZERO]  = (res_i == '0);
        flg_o[FB_SIGN]  = res_i[DW-1];
    end
endmodule

// File: rtl/bitops_alu.sv
module bitops_alu
    import bitops_pkg::*;
(
    input  logic [7:0] operand_i,
    input  logic [7:0] flags_i,
    input  logic [1:0] group_i,
    input  logic [2:0] sel_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o
);
    logic [DW-1:0] rs_res;
    logic          rs_carry;
    logic [DW-1:0] rs_flg;
    logic          bit_hit;
    logic [DW-1:0] bit_clr;
    logic [DW-1:0] bit_set;
    alu_out_t      alu_d;

    rotshift_unit u_rot (
        .val_i  (operand_i),
        .cin_i  (flags_i[FB_CARRY]),
        .kind_i (sel_i),
        .res_o  (rs_res),
        .cout_o (rs_carry)
    );

    shift_flag_gen u_sflg (
        .res_i   (rs_res),
        .carry_i (rs_carry),
        .flg_o   (rs_flg)
    );

    bitsel_unit u_bit (
        .val_i     (operand_i),
        .idx_i     (sel_i),
        .picked_o  (bit_hit),
        .cleared_o (bit_clr),
        .forced_o  (bit_set)
    );

    always_comb begin
        alu_d.res = operand_i;
        alu_d.flg = flags_i;
        unique case (grp_e'(group_i))
            GRP_SHIFT: begin
                alu_d.res = rs_res;
                alu_d.flg = rs_flg;
            end
            GRP_TEST: begin
                alu_d.res           = operand_i;
                alu_d.flg           = '0;
                alu_d.flg[FB_CARRY] = flags_i[FB_CARRY];
                alu_d.flg[FB_HALF]  = 1'b1;
                alu_d.flg[FB_ZERO]  = ~bit_hit;
                alu_d.flg[FB_PAR]   = ~bit_hit;
                alu_d.flg[FB_X5]    = operand_i[5];
                alu_d.flg[FB_X3]    = operand_i[3];
            end
            GRP_CLEAR: alu_d.res = bit_clr;
            GRP_FORCE: alu_d.res = bit_set;
            default: ;
        endcase
    end

    assign result_o = alu_d.res;
    assign flags_o  = alu_d.flg;
endmodule

// File: rtl/bitops_alu_chk.sv
module bitops_alu_chk (
    input logic [7:0] operand_i,
    input logic [7:0] flags_i,
    input logic [1:0] group_i,
    input logic [2:0] sel_i,
    input logic [7:0] result_o,
    input logic [7:0] flags_o
);
    logic [7:0] onehot;
    assign onehot = 8'h01 << sel_i;

    always_comb begin
        if (group_i == 2'd0) begin
            p_shift_hn_clear_r5: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0)
                else $error("R5 H/N not clear");
            p_shift_zero_r5: assert (flags_o[6] == (result_o == 8'h00))
                else $error("R5 zero flag mismatch");
            p_shift_copy_r5: assert (flags_o[7] == result_o[7] && flags_o[5] == result_o[5]
                                     && flags_o[3] == result_o[3])
                else $error("R5 copy bits mismatch");
        end
        if (group_i == 2'd1) begin
            p_test_pass_r7: assert (result_o == operand_i)
                else $error("R7 bit test altered operand");
            p_test_flags_r6: assert (flags_o[0] == flags_i[0] && flags_o[4] && !flags_o[7]
                                     && !flags_o[1] && flags_o[6] == flags_o[2])
                else $error("R6 bit test flags malformed");
        end
        if (group_i == 2'd2) begin
            p_clear_bit_r8: assert ((result_o & onehot) == 8'h00
                                    && (result_o | onehot) == (operand_i | onehot)
                                    && flags_o == flags_i)
                else $error("R8 clear wrong");
        end
        if (group_i == 2'd3) begin
            p_force_bit_r9: assert ((result_o & onehot) == onehot
                                    && (result_o & ~onehot) == (operand_i & ~onehot)
                                    && flags_o == flags_i)
                else $error("R9 set wrong");
        end
    end
endmodule

bind bitops_alu bitops_alu_chk u_chk (
    .operand_i (operand_i),
    .flags_i   (flags_i),
    .group_i   (group_i),
    .sel_i     (sel_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/bitops_alu_tb_top.sv
module bitops_alu_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] operand_i, flags_i, result_o, flags_o;
    logic [1:0] group_i;
    logic [2:0] sel_i;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bitops_alu dut_i (
        .operand_i (operand_i),
        .flags_i   (flags_i),
        .group_i   (group_i),
        .sel_i     (sel_i),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    // {group, sel, flags_in, operand, exp_result, exp_flags}
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 3'd0, 8'h00, 8'h80, 8'h01, 8'h01},  // R2 rotate left wrap
        {2'd0, 3'd1, 8'h00, 8'h01, 8'h80, 8'h81},  // R2 rotate right wrap
        {2'd0, 3'd2, 8'h01, 8'h80, 8'h01, 8'h01},  // R3 carry fills
        {2'd0, 3'd2, 8'h00, 8'h80, 8'h00, 8'h45},  // R3 zero with carry
        {2'd0, 3'd3, 8'h01, 8'h01, 8'h80, 8'h81},  // R3 right through carry
        {2'd0, 3'd4, 8'h00, 8'hFF, 8'hFE, 8'hA9},  // R4 shl0, R5 copy bits
        {2'd0, 3'd5, 8'h00, 8'h81, 8'hC0, 8'h85},  // R4 arithmetic right
        {2'd0, 3'd6, 8'h00, 8'h00, 8'h01, 8'h00},  // R4 shl fill 1
        {2'd0, 3'd7, 8'hFF, 8'h01, 8'h00, 8'h45},  // R4 shr0, R5 zero/parity
        {2'd1, 3'd7, 8'h00, 8'h80, 8'h80, 8'h10},  // R6 tested bit is 1
        {2'd1, 3'd0, 8'h01, 8'h28, 8'h28, 8'h7D},  // R6 R7 tested bit is 0
        {2'd2, 3'd3, 8'hA5, 8'hFF, 8'hF7, 8'hA5},  // R8
        {2'd3, 3'd6, 8'h42, 8'h00, 8'h40, 8'h42},  // R9
        {2'd0, 3'd1, 8'hFF, 8'h00, 8'h00, 8'h44}   // R1 R5 all-zero rotate
    };

    function automatic logic [15:0] model(input logic [1:0] g, input logic [2:0] s,
                                          input logic [7:0] f, input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] nf;
        logic       c;
        int         ones;
        r  = x;
        nf = f;
        c  = 1'b0;
        case (g)
            2'd0: begin
                case (s)
                    3'd0: begin c = x[7]; r = {x[6:0], x[7]}; end
                    3'd1: begin c = x[0]; r = {x[0], x[7:1]}; end
                    3'd2: begin c = x[7]; r = {x[6:0], f[0]}; end
                    3'd3: begin c = x[0]; r = {f[0], x[7:1]}; end
                    3'd4: begin c = x[7]; r = x << 1; end
                    3'd5: begin c = x[0]; r = {x[7], x[7:1]}; end
                    3'd6: begin c = x[7]; r = (x << 1) | 8'h01; end
                    default: begin c = x[0]; r = x >> 1; end
                endcase
                ones = 0;
                for (int i = 0; i < 8; i++) ones += int'(r[i]);
                nf = (r & 8'hA8) | {7'd0, c};
                if (r == 8'h00) nf = nf | 8'h40;
                if (ones % 2 == 0) nf = nf | 8'h04;
            end
            2'd1: begin
                nf = (x & 8'h28) | (f & 8'h01) | 8'h10;
                if (!x[s]) nf = nf | 8'h44;
            end
            2'd2: r[s] = 1'b0;
            default: r[s] = 1'b1;
        endcase
        return {r, nf};
    endfunction

    task automatic apply(input logic [1:0] g, input logic [2:0] s, input logic [7:0] f,
                         input logic [7:0] x, input logic [15:0] exp, input string tag);
        @(posedge clk);
        group_i   = g;
        sel_i     = s;
        flags_i   = f;
        operand_i = x;
        @(negedge clk);
        n_vec++;
        if ({result_o, flags_o} !== exp) begin
            n_fail++;
            $display("FAIL %s grp=%0d sel=%0d f=%h x=%h actual=%h/%h expected=%h/%h",
                     tag, g, s, f, x, result_o, flags_o, exp[15:8], exp[7:0]);
        end
    endtask

    localparam logic [7:0] FPAT [4] = '{8'h00, 8'h01, 8'hFE, 8'hFF};

    initial begin
        group_i = '0; sel_i = '0; flags_i = '0; operand_i = '0;
        for (int v = 0; v < NV; v++)
            apply(VEC[v][36:35], VEC[v][34:32], VEC[v][31:24], VEC[v][23:16],
                  VEC[v][15:0], "table R1-vector");
        // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int g = 0; g < 4; g++)
            for (int s = 0; s < 8; s++)
                for (int fp = 0; fp < 4; fp++)
                    for (int x = 0; x < 256; x++)
                        apply(2'(g), 3'(s), FPAT[fp], 8'(x),
                              model(2'(g), 3'(s), FPAT[fp], 8'(x)), "sweep");
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule